// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns characters taken from a transmit FIFO into asynchronous serial frames on a transmit line. Each frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of one or one and a half bit times. The line idles high. Bit timing comes from outside: a one-cycle `bit_tick` strobe marks each bit boundary. A `half_tick` strobe, placed halfway between bit ticks, ends a stop period of one and a half bits.

The parity bit can be even, odd, always one (mark) or always zero (space). Even and odd parity can be computed from the count of ones or the count of zeros in the character. A break control forces every bit of a frame low. Optional hardware flow control holds back the start of a new frame until the clear-to-send input is asserted, with the asserted level selectable. A null-modem setting swaps the pins used for transmit data and for clear-to-send. When the block is disabled it stops at once, returns the line to idle and requests a flush of the FIFO.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, both transmit pins are high, `busy` is low and `fifo_pop` is low.
- R2: A frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts one `bit_tick` period. The `char_size` code selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: With `parity_en`=1, one parity bit follows the data bits. With `parity_mode`=0 (even) the parity bit is 1 when the counted bits are odd in number. With `parity_mode`=1 (odd) the parity bit is the inverse of that.
- R4: With `parity_on_zeros`=0 the counted bits are the ones of the character. With `parity_on_zeros`=1 they are its zeros, taken over the selected character size only.
- R5: `parity_mode`=2 sends a parity bit of 1, and `parity_mode`=3 sends a parity bit of 0, whatever the data.
- R6: With `stop_half`=1 the stop level is held for the first full stop bit and then until the next `half_tick`, which gives 1.5 bit times.
- R7: While `break_en`=1, every bit of a frame is 0, including the start, parity and stop bits. The line still idles high between frames.
- R8: With `flow_en`=1, a frame starts only when the selected CTS input equals `flow_pol` (1 means asserted high). While CTS is not asserted, the FIFO is not popped.
- R9: CTS is sampled only when a frame starts. A frame that has started always runs to its end.
- R10: With `null_modem`=1 the frame is driven on `txd_alt`, `txd_main` stays high, and CTS is read from `cts_b`. With `null_modem`=0 these roles are reversed: the frame goes on `txd_main`, `txd_alt` stays high, and CTS is read from `cts_a`.
- R11: When `enable`=0, the block goes idle on the next clock. Both pins return high, `busy` goes low, `fifo_flush` is high and no pop occurs.
- R12: `busy` is high from the start bit to the end of the final stop period. With one stop bit, a pending character starts at the bit tick that ends the stop bit, with no idle gap.
- R13: Exactly one `fifo_pop` pulse occurs per frame, in the cycle of the bit tick that starts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| char_size | input | 2 | Data length code (5 + code bits) |
| parity_en | input | 1 | Adds a parity bit |
| parity_mode | input | 2 | 0 even, 1 odd, 2 mark, 3 space |
| parity_on_zeros | input | 1 | Parity counts zeros instead of ones |
| stop_half | input | 1 | 1.5 stop bits when set |
| break_en | input | 1 | Forces frame bits low |
| flow_en | input | 1 | CTS gating of frame starts |
| flow_pol | input | 1 | Asserted level of CTS |
| null_modem | input | 1 | Swaps the data and CTS pins |
| bit_tick | input | 1 | Bit boundary strobe |
| half_tick | input | 1 | Half-bit strobe |
| fifo_empty | input | 1 | FIFO has no character |
| fifo_data | input | 8 | Character at the FIFO head |
| cts_a | input | 1 | CTS pin in direct mode |
| cts_b | input | 1 | CTS pin in null-modem mode |
| fifo_pop | output | 1 | Takes the FIFO head character |
| fifo_flush | output | 1 | FIFO flush request while disabled |
| txd_main | output | 1 | Transmit pin in direct mode |
| txd_alt | output | 1 | Transmit pin in null-modem mode |
| busy | output | 1 | A frame is in progress |

## Verification
A wrong bit counter or shift register shows up at once on the transmit pin. The frame gets the wrong bit in some bit slot, or a stop period that starts one bit period early or late, so every frame is compared slot by slot for each clock cycle against a model built from the configuration. A stale parity or stop setting changes one specific slot, or the frame length by half a bit. A state machine stuck in or out of idle shows as `busy` or `fifo_pop` off by whole bit periods, or as a character sent while CTS is withheld. These faults are caught within the frame in which they occur.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] char_size,
  input  logic       parity_en,
  input  logic [1:0] parity_mode,
  input  logic       parity_on_zeros,
  input  logic       stop_half,
  input  logic       break_en,
  input  logic       flow_en,
  input  logic       flow_pol,
  input  logic       null_modem,
  input  logic       bit_tick,
  input  logic       half_tick,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  input  logic       cts_a,
  input  logic       cts_b,
  output logic       fifo_pop,
  output logic       fifo_flush,
  output logic       txd_main,
  output logic       txd_alt,
  output logic       busy
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HALF} st_t;

  st_t        st;
  logic [7:0] sh;
  logic [2:0] cnt, last;
  logic       par_on, par_bit, half_r;

  logic       cts_in, cts_ok, ready, launch;
  logic [7:0] masked;
  logic       cnt_odd, par_new, bitval, line;

  assign cts_in  = null_modem ? cts_b : cts_a;
  assign cts_ok  = !flow_en || (cts_in == flow_pol);
  assign ready   = enable && !fifo_empty && cts_ok && bit_tick;
  assign launch  = ready && (st == S_IDLE || (st == S_STOP && !half_r));
  assign fifo_pop   = launch;
  assign fifo_flush = !enable;

  assign masked  = fifo_data & (8'hFF >> (2'd3 - char_size));
  assign cnt_odd = (^masked) ^ (parity_on_zeros & ~char_size[0]);

  always_comb begin
    case (parity_mode)
      2'd0:    par_new = cnt_odd;
      2'd1:    par_new = ~cnt_odd;
      2'd2:    par_new = 1'b1;
      default: par_new = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sh <= '0;
      cnt <= '0;
      last <= '0;
      par_on <= 1'b0;
      par_bit <= 1'b0;
      half_r <= 1'b0;
    end else if (!enable) begin
      st <= S_IDLE;
    end else if (launch) begin
      st <= S_START;
      sh <= fifo_data;
      last <= {1'b0, char_size} + 3'd4;
      par_on <= parity_en;
      par_bit <= par_new;
      half_r <= stop_half;
    end else begin
      case (st)
        S_START: if (bit_tick) begin
          st <= S_DATA;
          cnt <= '0;
        end
        S_DATA: if (bit_tick) begin
          if (cnt == last) st <= par_on ? S_PAR : S_STOP;
          else begin
            sh <= sh >> 1;
            cnt <= cnt + 3'd1;
          end
        end
        S_PAR:  if (bit_tick) st <= S_STOP;
        S_STOP: if (bit_tick) st <= half_r ? S_HALF : S_IDLE;
        S_HALF: if (half_tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_START: bitval = 1'b0;
      S_DATA:  bitval = sh[0];
      S_PAR:   bitval = par_bit;
      default: bitval = 1'b1;
    endcase
  end

  assign busy     = (st != S_IDLE);
  assign line     = (busy && break_en) ? 1'b0 : bitval;
  assign txd_main = null_modem ? 1'b1 : line;
  assign txd_alt  = null_modem ? line : 1'b1;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd_main && txd_alt));

  assert_half_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALF && !break_en) |-> (txd_main && txd_alt));

  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && break_en) |-> !(txd_main && txd_alt));

  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && flow_en) |-> ((null_modem ? cts_b : cts_a) == flow_pol));

  assert_disable_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !fifo_pop));

  assert_pop_starts_R13: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (!fifo_empty && bit_tick));

  assert_pop_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && enable) |=> busy);

endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/100ps
module uart_frame_tx_tb_top;

  logic clk = 0, rst_n = 0;
  logic enable = 1;
  logic [1:0] char_size = 3;
  logic parity_en = 0;
  logic [1:0] parity_mode = 0;
  logic parity_on_zeros = 0, stop_half = 0, break_en = 0;
  logic flow_en = 0, flow_pol = 1, null_modem = 0;
  logic bit_tick = 0, half_tick = 0;
  logic fifo_empty = 1;
  logic [7:0] fifo_data = 0;
  logic cts_a = 1, cts_b = 1;
  logic fifo_pop, fifo_flush, txd_main, txd_alt, busy;

  uart_frame_tx dut_i (.*);

  always #2.5 clk = ~clk;

  logic [2:0] ph = 0;
  always @(negedge clk) begin
    ph <= ph + 3'd1;
    bit_tick <= (ph == 3'd7);
    half_tick <= (ph == 3'd3);
  end

  typedef struct {
    logic [11:0] bits;
    int nb;
    bit half;
    string tag;
  } item_t;

  logic [7:0] fq[$];
  item_t expq[$];
  int errors = 0, checks = 0, pops = 0, frames = 0, aborted = 0;
  bit mon_on = 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (fifo_flush) fq.delete();
    else if (fifo_pop && fq.size() > 0) begin
      void'(fq.pop_front());
      pops++;
    end
  end

  always @(negedge clk) begin
    fifo_empty <= (fq.size() == 0);
    fifo_data <= (fq.size() > 0) ? fq[0] : 8'h00;
  end

  function automatic item_t mk(input logic [7:0] d, input string tag);
    item_t it;
    int n, ones, c;
    logic pb;
    n = 5 + int'(char_size);
    it.bits = '0;
    it.bits[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      it.bits[1 + i] = d[i];
      ones += int'(d[i]);
    end
    it.nb = 1 + n;
    c = parity_on_zeros ? (n - ones) : ones;
    case (parity_mode)
      2'd0: pb = (c % 2 == 1);
      2'd1: pb = (c % 2 == 0);
      2'd2: pb = 1'b1;
      default: pb = 1'b0;
    endcase
    if (parity_en) begin
      it.bits[it.nb] = pb;
      it.nb++;
    end
    it.bits[it.nb] = 1'b1;
    it.nb++;
    if (break_en) it.bits = '0;
    it.half = stop_half;
    it.tag = tag;
    return it;
  endfunction

  task automatic send(input logic [7:0] d, input string tag);
    expq.push_back(mk(d, tag));
    fq.push_back(d);
  endtask

  initial begin : monitor
    item_t it;
    bit carry = 0;
    int bad, len, first_bad;
    logic e, a, o;
    forever begin
      if (!carry) @(negedge clk);
      carry = 0;
      if (mon_on && busy) begin
        if (expq.size() == 0) begin
          chk(0, "R12", "unexpected frame", 1, 0);
          while (busy) @(negedge clk);
        end else begin
          it = expq.pop_front();
          len = it.nb * 8 + (it.half ? 4 : 0);
          bad = 0;
          first_bad = -1;
          for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            e = (i / 8 < it.nb) ? it.bits[i / 8] : it.bits[it.nb - 1];
            a = null_modem ? txd_alt : txd_main;
            o = null_modem ? txd_main : txd_alt;
            if (a !== e || o !== 1'b1 || busy !== 1'b1) begin
              bad++;
              if (first_bad < 0) first_bad = i;
            end
          end
          @(negedge clk);
          a = null_modem ? txd_alt : txd_main;
          if (!(busy === 1'b0 || a === 1'b0 || break_en)) begin
            bad++;
            if (first_bad < 0) first_bad = len;
          end
          chk(bad == 0, it.tag, "frame mismatch cycles, first bad cycle", bad, 0);
          if (bad != 0) $display("  first bad cycle %0d", first_bad);
          frames++;
          carry = 1;
        end
      end
    end
  end

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 20) begin
      @(negedge clk);
      if (expq.size() == 0 && fq.size() == 0 && !busy) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd_main === 1 && txd_alt === 1, "R1", "idle pins", {txd_main, txd_alt}, 3);
    chk(busy === 0 && fifo_pop === 0, "R1", "busy/pop after reset", {busy, fifo_pop}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 / R12: 8-bit frames back to back
    send(8'hA5, "R2"); send(8'h3C, "R12"); send(8'h01, "R2");
    wait_idle();
    // R2: other sizes
    char_size = 0; send(8'hFF, "R2"); send(8'h0A, "R2"); wait_idle();
    char_size = 1; send(8'h2D, "R2"); wait_idle();
    char_size = 2; send(8'h55, "R2"); wait_idle();
    // R3: even and odd parity over ones
    char_size = 3; parity_en = 1; parity_mode = 0;
    send(8'h07, "R3"); send(8'h03, "R3"); wait_idle();
    parity_mode = 1; send(8'h07, "R3"); send(8'h00, "R3"); wait_idle();
    // R4: zeros count, odd-length character
    parity_on_zeros = 1; char_size = 0; parity_mode = 0;
    send(8'h01, "R4"); send(8'hE3, "R4"); wait_idle();
    char_size = 2; parity_mode = 1; send(8'h0F, "R4"); wait_idle();
    parity_on_zeros = 0;
    // R5: mark and space
    char_size = 3; parity_mode = 2; send(8'h00, "R5"); send(8'hFF, "R5"); wait_idle();
    parity_mode = 3; send(8'hFF, "R5"); wait_idle();
    parity_en = 0;
    // R6: 1.5 stop bits
    stop_half = 1; send(8'h96, "R6"); send(8'h69, "R6"); wait_idle();
    stop_half = 0;
    // R7: break
    break_en = 1; send(8'hFF, "R7"); wait_idle();
    break_en = 0;
    @(negedge clk);
    chk(txd_main === 1, "R7", "line high after break frame", txd_main, 1);

    // R8: flow control, asserted high
    flow_en = 1; flow_pol = 1; cts_a = 0;
    send(8'h5A, "R8");
    repeat (100) @(negedge clk);
    chk(busy === 0 && fq.size() == 1, "R8", "held while CTS low (busy,fifo)", busy * 10 + fq.size(), 1);
    cts_a = 1; wait_idle();
    // R8: asserted low
    flow_pol = 0; send(8'hC3, "R8");
    repeat (100) @(negedge clk);
    chk(busy === 0 && fq.size() == 1, "R8", "held with low polarity", busy * 10 + fq.size(), 1);
    cts_a = 0; wait_idle();

    // R9: CTS drop mid-frame
    flow_pol = 1; cts_a = 1;
    send(8'h81, "R9");
    fq.push_back(8'h42);
    while (!busy) @(negedge clk);
    repeat (20) @(negedge clk);
    cts_a = 0;
    repeat (150) @(negedge clk);
    chk(busy === 0 && fq.size() == 1 && expq.size() == 0, "R9", "second frame held, fifo", fq.size(), 1);
    expq.push_back(mk(8'h42, "R9"));
    cts_a = 1; wait_idle();

    // R10: null modem
    null_modem = 1; cts_a = 1; cts_b = 0;
    send(8'h3E, "R10");
    repeat (100) @(negedge clk);
    chk(busy === 0 && fq.size() == 1, "R10", "CTS read from alt pin", fq.size(), 1);
    cts_b = 1; wait_idle();
    null_modem = 0; flow_en = 0;

    // R11: disable mid-frame
    mon_on = 0;
    fq.push_back(8'hAA); fq.push_back(8'hBB); fq.push_back(8'hCC);
    while (!busy) @(negedge clk);
    repeat (20) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk(busy === 0 && txd_main === 1 && txd_alt === 1, "R11", "idle after disable", busy, 0);
    chk(fifo_flush === 1 && fq.size() == 0, "R11", "flush (fifo size)", fq.size(), 0);
    repeat (40) @(negedge clk);
    chk(busy === 0 && pops == frames + 1, "R11", "no pop while disabled (pops)", pops, frames + 1);
    aborted = 1;
    enable = 1; mon_on = 1;
    repeat (20) @(negedge clk);

    send(8'h99, "R13"); wait_idle();
    chk(pops == frames + aborted, "R13", "one pop per frame", pops, frames + aborted);
    finish_run();
  end

endmodule